// File: doc/BRIEF.md
# Tile Configuration Control Register

This block owns the shape configuration for a bank of eight two-dimensional tile registers. Software-visible state is a 64-byte configuration image. It is written in eight 64-bit beats and read back one beat at a time. The image carries a palette selector and, for every tile, a row count and a bytes-per-row width. The block checks a new image against the limits of the chosen palette. It then applies the image as one atomic update and presents a valid flag and a decoded shape for each tile, for use by the tile load, store and compute datapaths.

A one-cycle release command returns the configuration to its initial state. That state is the same as the result of loading palette 0: every tile becomes invalid, so no tile content needs to be preserved. Palette 0 (no tiles) and palette 1 (eight tiles of at most 16 rows by 64 bytes) are the only supported palettes. A rejected image raises an error pulse and leaves the live configuration as it was.

Top module: `tile_cfg_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, palette, tile_valid, tile_rows, tile_colb, ld_done and ld_err are all zero.
- R2: Image layout. Beat b carries bytes 8b to 8b+7, and byte 8b+k sits in bits 8k+7:8k. Byte 0 is the palette. Tile t's bytes-per-row is a little-endian 16-bit field at bytes 16+2t and 17+2t. Tile t's row count is byte 48+t. All other bytes are reserved.
- R3: A load is eight beats with ld_beat equal to 0,1,...,7 in order. Idle cycles are allowed between beats. Outputs keep their old values until the clock edge that accepts beat 7. They take the new values at that edge, and ld_done is high for the one following cycle.
- R4: tile_valid[t] is 1 exactly when tile t's row count and bytes-per-row are both nonzero.
- R5: An accepted image whose palette byte is 0 clears every field and every valid flag, whatever its other bytes hold.
- R6: With palette 1, a row count above 16 or a bytes-per-row above 64 in any tile rejects the image. ld_err is high for the cycle after beat 7 and the configuration is unchanged. The values 16 and 64 themselves are accepted.
- R7: With palette 1, any nonzero reserved byte rejects the image in the same way as R6.
- R8: A palette byte other than 0 or 1 rejects the image in the same way as R6.
- R9: A beat whose ld_beat differs from the expected index is dropped. It aborts the load in progress and raises ld_err in the next cycle. The next load must start again at beat 0.
- R10: rel_req clears the configuration at the next clock edge and aborts any load in progress. A beat presented in the same cycle is ignored. When that beat is beat 7, neither ld_done nor ld_err follows.
- R11: st_data combinationally returns beat st_beat of the current image in the R2 layout, with reserved bytes zero. It is all zeros after reset or release.
- R12: ld_done and ld_err are never high in the same cycle, and each is a single-cycle pulse per load outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load beat is presented |
| ld_beat | input | 3 | Index of the presented load beat |
| ld_data | input | 64 | Load beat data, R2 byte order |
| rel_req | input | 1 | Release: return to initial configuration |
| st_beat | input | 3 | Index of the beat to read back |
| st_data | output | 64 | Read-back beat of the current image |
| ld_done | output | 1 | Pulse: image accepted |
| ld_err | output | 1 | Pulse: image or beat rejected |
| palette | output | 8 | Current palette |
| tile_valid | output | 8 | Per-tile valid flags |
| tile_rows | output | 64 | Row count of tile t in bits 8t+7:8t |
| tile_colb | output | 128 | Bytes per row of tile t in bits 16t+15:16t |

## Verification
Release and the final load beat can land on the same clock edge, and release must win. The bench asserts rel_req together with beat 7 of an image that would otherwise be accepted. It expects the configuration to be cleared in the next cycle, with no ld_done and no ld_err. A release in the middle of a load is also sent, followed by the rest of its beats. Those later beats must be treated as out-of-order errors, not as a continuation. A cycle-accurate model in the bench compares every output on every clock.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
  localparam int IMG_BYTES  = 64;
  localparam int BEAT_BYTES = 8;
  localparam int BEAT_W     = BEAT_BYTES * 8;
  localparam int N_BEATS    = IMG_BYTES / BEAT_BYTES;
  localparam int PAL_BYTE   = 0;
  localparam int COLB_BYTE  = 16;
  localparam int ROWS_BYTE  = 48;

  typedef enum logic [7:0] {
    PAL_INIT  = 8'd0,
    PAL_TILES = 8'd1
  } pal_e;

  // true for bytes that carry a palette or shape field for nt tiles
  function automatic logic is_field(int b, int nt);
    return (b == PAL_BYTE) ||
           (b >= COLB_BYTE && b < COLB_BYTE + 2 * nt) ||
           (b >= ROWS_BYTE && b < ROWS_BYTE + nt);
  endfunction
endpackage

// File: rtl/tcfg_stage.sv
module tcfg_stage
  import tcfg_pkg::*;
#(
  parameter int DW = 64,
  parameter int NB = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic [$clog2(NB)-1:0]  ld_beat,
  input  logic [DW-1:0]          ld_data,
  input  logic                   abort,
  output logic [NB*DW-1:0]       img,
  output logic                   commit,
  output logic                   seq_err
);
  localparam int BW = $clog2(NB);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          hit;

  always_comb begin
    hit     = ld_valid && !abort && (ld_beat == cnt_q);
    commit  = hit && (cnt_q == BW'(NB - 1));
    seq_err = ld_valid && !abort && !hit;
    cnt_d   = cnt_q;
    if (abort || seq_err || commit) cnt_d = '0;
    else if (hit)                   cnt_d = cnt_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // beats 0..NB-2 are held; the last beat is used straight from the input
  for (genvar b = 0; b < NB - 1; b++) begin : g_beat
    logic [DW-1:0] stg_q;
    logic          we;
    assign we = hit && (cnt_q == BW'(b));
    always_ff @(posedge clk) begin
      if (we) stg_q <= ld_data;
    end
    assign img[b*DW +: DW] = stg_q;
  end
  assign img[(NB-1)*DW +: DW] = ld_data;
endmodule

// File: rtl/tcfg_decode.sv
module tcfg_decode
  import tcfg_pkg::*;
#(
  parameter int NT       = 8,
  parameter int MAX_ROWS = 16,
  parameter int MAX_COLB = 64,
  parameter int RW       = 5,
  parameter int CW       = 7
) (
  input  logic [IMG_BYTES*8-1:0] img,
  output logic                   ok,
  output logic                   pal_sel,
  output logic [NT*RW-1:0]       rows_n,
  output logic [NT*CW-1:0]       colb_n
);
  logic [7:0]  pal;
  logic        res_bad, over;
  logic [7:0]  r;
  logic [15:0] c;

  always_comb begin
    pal     = img[8*PAL_BYTE +: 8];
    res_bad = 1'b0;
    over    = 1'b0;
    rows_n  = '0;
    colb_n  = '0;
    r       = '0;
    c       = '0;
    for (int b = 0; b < IMG_BYTES; b++) begin
      if (!is_field(b, NT) && (img[8*b +: 8] != 8'd0)) res_bad = 1'b1;
    end
    for (int t = 0; t < NT; t++) begin
      r = img[8*(ROWS_BYTE + t) +: 8];
      c = img[8*(COLB_BYTE + 2*t) +: 16];
      if ((r > 8'(MAX_ROWS)) || (c > 16'(MAX_COLB))) over = 1'b1;
      rows_n[t*RW +: RW] = r[RW-1:0];
      colb_n[t*CW +: CW] = c[CW-1:0];
    end
    pal_sel = (pal == PAL_TILES);
    ok      = (pal == PAL_INIT) || (pal_sel && !res_bad && !over);
    if (!pal_sel) begin
      rows_n = '0;
      colb_n = '0;
    end
  end
endmodule

// File: rtl/tile_cfg_ctrl.sv
module tile_cfg_ctrl
  import tcfg_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int MAX_ROWS  = 16,
  parameter int MAX_COLB  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_valid,
  input  logic [$clog2(N_BEATS)-1:0] ld_beat,
  input  logic [BEAT_W-1:0]          ld_data,
  input  logic                       rel_req,
  input  logic [$clog2(N_BEATS)-1:0] st_beat,
  output logic [BEAT_W-1:0]          st_data,
  output logic                       ld_done,
  output logic                       ld_err,
  output logic [7:0]                 palette,
  output logic [NUM_TILES-1:0]       tile_valid,
  output logic [NUM_TILES*8-1:0]     tile_rows,
  output logic [NUM_TILES*16-1:0]    tile_colb
);
  localparam int RW    = $clog2(MAX_ROWS + 1);
  localparam int CW    = $clog2(MAX_COLB + 1);
  localparam int IMG_W = IMG_BYTES * 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [IMG_W-1:0]        new_img;
  logic                    commit, seq_err, img_ok, pal_sel;
  logic [NUM_TILES*RW-1:0] rows_n;
  logic [NUM_TILES*CW-1:0] colb_n;

  tcfg_stage #(.DW(BEAT_W), .NB(N_BEATS)) u_stage (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ld_valid(ld_valid),
    .ld_beat (ld_beat),
    .ld_data (ld_data),
    .abort   (rel_req),
    .img     (new_img),
    .commit  (commit),
    .seq_err (seq_err)
  );

  tcfg_decode #(
    .NT(NUM_TILES), .MAX_ROWS(MAX_ROWS), .MAX_COLB(MAX_COLB), .RW(RW), .CW(CW)
  ) u_decode (
    .img    (new_img),
    .ok     (img_ok),
    .pal_sel(pal_sel),
    .rows_n (rows_n),
    .colb_n (colb_n)
  );

  // live configuration
  logic                    pal_q, pal_d;
  logic [NUM_TILES*RW-1:0] rows_q, rows_d;
  logic [NUM_TILES*CW-1:0] colb_q, colb_d;
  logic                    cfg_we, done_q, done_d, err_q, err_d;

  always_comb begin
    cfg_we = rel_req || (commit && img_ok);
    pal_d  = rel_req ? 1'b0 : pal_sel;
    rows_d = rel_req ? '0   : rows_n;
    colb_d = rel_req ? '0   : colb_n;
    done_d = commit && img_ok;
    err_d  = seq_err || (commit && !img_ok);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pal_q  <= 1'b0;
      rows_q <= '0;
      colb_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        pal_q  <= pal_d;
        rows_q <= rows_d;
        colb_q <= colb_d;
      end
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign ld_done = done_q;
  assign ld_err  = err_q;
  assign palette = pal_q ? PAL_TILES : PAL_INIT;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    assign tile_rows[8*t +: 8]   = 8'(rows_q[t*RW +: RW]);
    assign tile_colb[16*t +: 16] = 16'(colb_q[t*CW +: CW]);
    assign tile_valid[t] = (|rows_q[t*RW +: RW]) && (|colb_q[t*CW +: CW]);
  end

  // read-back image rebuilt from the live fields
  logic [IMG_W-1:0] img_rd;
  always_comb begin
    img_rd = '0;
    img_rd[8*PAL_BYTE +: 8] = palette;
    for (int t = 0; t < NUM_TILES; t++) begin
      img_rd[8*(COLB_BYTE + 2*t) +: 16] = tile_colb[16*t +: 16];
      img_rd[8*(ROWS_BYTE + t) +: 8]    = tile_rows[8*t +: 8];
    end
  end
  assign st_data = img_rd[st_beat*BEAT_W +: BEAT_W];
endmodule

// File: rtl/tile_cfg_ctrl_sva.sv
module tile_cfg_ctrl_sva #(
  parameter int NUM_TILES = 8,
  parameter int MAX_ROWS  = 16,
  parameter int MAX_COLB  = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ld_valid,
  input logic                    rel_req,
  input logic                    ld_done,
  input logic                    ld_err,
  input logic [7:0]              palette,
  input logic [NUM_TILES-1:0]    tile_valid,
  input logic [NUM_TILES*8-1:0]  tile_rows,
  input logic [NUM_TILES*16-1:0] tile_colb,
  input logic [63:0]             st_data
);
  p_release_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req |=> (tile_valid == '0 && palette == 8'd0 && tile_rows == '0 && tile_colb == '0));

  p_done_err_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_done && ld_err));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> !ld_done);

  p_reject_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> ($stable(tile_rows) && $stable(tile_colb) && $stable(palette)));

  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid && !rel_req) |=> ($stable(tile_rows) && $stable(tile_colb) && $stable(palette)));

  p_palette_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    palette <= 8'd1);

  p_init_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (palette == 8'd0) |-> (st_data == '0 || tile_valid == '0));

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_lim
    p_rows_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tile_rows[8*t +: 8] <= 8'(MAX_ROWS));
    p_colb_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tile_colb[16*t +: 16] <= 16'(MAX_COLB));
  end
endmodule

bind tile_cfg_ctrl tile_cfg_ctrl_sva #(
  .NUM_TILES(NUM_TILES), .MAX_ROWS(MAX_ROWS), .MAX_COLB(MAX_COLB)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .rel_req   (rel_req),
  .ld_done   (ld_done),
  .ld_err    (ld_err),
  .palette   (palette),
  .tile_valid(tile_valid),
  .tile_rows (tile_rows),
  .tile_colb (tile_colb),
  .st_data   (st_data)
);

// File: tb/tile_cfg_ctrl_tb.sv
module tile_cfg_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         ld_valid, rel_req;
  logic [2:0]   ld_beat, st_beat;
  logic [63:0]  ld_data, st_data;
  logic         ld_done, ld_err;
  logic [7:0]   palette;
  logic [7:0]   tile_valid;
  logic [63:0]  tile_rows;
  logic [127:0] tile_colb;

  always #10 clk = ~clk;

  tile_cfg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_beat(ld_beat),
    .ld_data(ld_data), .rel_req(rel_req), .st_beat(st_beat), .st_data(st_data),
    .ld_done(ld_done), .ld_err(ld_err), .palette(palette),
    .tile_valid(tile_valid), .tile_rows(tile_rows), .tile_colb(tile_colb)
  );

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    started = 0;

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_cur [64];
  logic [7:0] m_stg [64];
  int         m_cnt;
  logic       m_done, m_err;

  function automatic bit img_ok();
    int c;
    if (m_stg[0] == 8'd0) return 1;
    if (m_stg[0] != 8'd1) return 0;
    for (int i = 1; i < 64; i++)
      if (!((i >= 16 && i < 32) || (i >= 48 && i < 56)) && m_stg[i] != 8'd0) return 0;
    for (int t = 0; t < 8; t++) begin
      c = {m_stg[17 + 2*t], m_stg[16 + 2*t]};
      if (m_stg[48 + t] > 8'd16 || c > 64) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m_cur[i] = 8'd0;
      m_cnt = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (rel_req) begin
        for (int i = 0; i < 64; i++) m_cur[i] = 8'd0;
        m_cnt = 0;
      end else if (ld_valid) begin
        if (int'(ld_beat) != m_cnt) begin
          m_err = 1; m_cnt = 0;
        end else begin
          for (int k = 0; k < 8; k++) m_stg[8*m_cnt + k] = ld_data[8*k +: 8];
          if (m_cnt == 7) begin
            if (img_ok()) begin
              for (int i = 0; i < 64; i++) m_cur[i] = (m_stg[0] == 8'd0) ? 8'd0 : m_stg[i];
              m_done = 1;
            end else m_err = 1;
            m_cnt = 0;
          end else m_cnt++;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      logic [7:0]   ev;
      logic [63:0]  er;
      logic [127:0] ec;
      for (int t = 0; t < 8; t++) begin
        er[8*t +: 8]   = m_cur[48 + t];
        ec[16*t +: 16] = {m_cur[17 + 2*t], m_cur[16 + 2*t]};
        ev[t] = (m_cur[48 + t] != 0) && ({m_cur[17 + 2*t], m_cur[16 + 2*t]} != 0);
      end
      chk(cur_req, "palette", 128'(palette), 128'(m_cur[0]));
      chk(cur_req, "tile_rows", 128'(tile_rows), 128'(er));
      chk(cur_req, "tile_colb", tile_colb, ec);
      chk("R4", "tile_valid", 128'(tile_valid), 128'(ev));
      chk(cur_req, "ld_done", 128'(ld_done), 128'(m_done));
      chk(cur_req, "ld_err", 128'(ld_err), 128'(m_err));
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] timg [64];

  task automatic clear_img();
    for (int i = 0; i < 64; i++) timg[i] = 8'd0;
  endtask

  task automatic set_shape(input int t, input int rows, input int colb);
    timg[48 + t]    = 8'(rows);
    timg[16 + 2*t]  = 8'(colb);
    timg[17 + 2*t]  = 8'(colb >> 8);
  endtask

  function automatic logic [63:0] beat_of(input int b);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = timg[8*b + k];
    return d;
  endfunction

  task automatic drive_beat(input int b, input bit rel);
    @(negedge clk);
    ld_valid = 1'b1; ld_beat = 3'(b); ld_data = beat_of(b); rel_req = rel;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    ld_valid = 1'b0; rel_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_load(input bit gaps, input bit rel_last);
    for (int b = 0; b < 8; b++) begin
      drive_beat(b, (b == 7) && rel_last);
      if (gaps && b != 7) idle(0);
    end
    idle(1);
  endtask

  task automatic release_now();
    @(negedge clk);
    ld_valid = 1'b0; rel_req = 1'b1;
    idle(1);
  endtask

  task automatic check_store(input string tag);
    for (int b = 0; b < 8; b++) begin
      logic [63:0] e;
      @(negedge clk);
      st_beat = 3'(b);
      #2;
      for (int k = 0; k < 8; k++) e[8*k +: 8] = m_cur[8*b + k];
      chk(tag, "st_data", 128'(st_data), 128'(e));
    end
  endtask

  task automatic good_img();
    clear_img();
    timg[0] = 8'd1;
    set_shape(0, 16, 64);
    set_shape(1, 3, 10);
    set_shape(2, 0, 8);
    set_shape(3, 5, 0);
    set_shape(7, 1, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; rel_req = 1'b0;
    ld_beat = '0; ld_data = '0; st_beat = '0;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1", "palette", 128'(palette), 128'd0);
    chk("R1", "tile_valid", 128'(tile_valid), 128'd0);
    chk("R1", "tile_rows", 128'(tile_rows), 128'd0);
    chk("R1", "ld_done/ld_err", 128'({ld_done, ld_err}), 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    started = 1;
    check_store("R11");

    // R2 R3 R4: accepted palette-1 image, boundary shape 16x64 included
    cur_req = "R3";
    good_img();
    send_load(1'b1, 1'b0);
    check_store("R2");

    // R12: back-to-back load with a different shape, no gaps
    cur_req = "R12";
    good_img();
    set_shape(5, 9, 33);
    send_load(1'b0, 1'b0);

    // R6: rows over limit, then bytes-per-row over limit
    cur_req = "R6";
    good_img(); set_shape(4, 17, 4);
    send_load(1'b0, 1'b0);
    good_img(); set_shape(6, 2, 65);
    send_load(1'b0, 1'b0);

    // R7: nonzero reserved byte
    cur_req = "R7";
    good_img(); timg[40] = 8'h01;
    send_load(1'b0, 1'b0);

    // R8: unsupported palette
    cur_req = "R8";
    good_img(); timg[0] = 8'd2;
    send_load(1'b0, 1'b0);
    check_store("R8");

    // R9: beat 3 out of order, then a full good load
    cur_req = "R9";
    good_img(); set_shape(6, 12, 20);
    drive_beat(0, 0); drive_beat(1, 0); drive_beat(3, 0);
    idle(1);
    send_load(1'b0, 1'b0);

    // R10: release in the middle of a load, remaining beats rejected
    cur_req = "R10";
    for (int b = 0; b < 4; b++) drive_beat(b, 0);
    release_now();
    for (int b = 4; b < 8; b++) drive_beat(b, 0);
    idle(1);
    check_store("R10");

    // R10: release in the same cycle as beat 7 of a valid image
    good_img();
    send_load(1'b0, 1'b0);
    send_load(1'b0, 1'b1);
    check_store("R11");

    // R5: palette 0 with junk in other bytes clears everything
    cur_req = "R5";
    good_img();
    send_load(1'b0, 1'b0);
    for (int i = 1; i < 64; i++) timg[i] = 8'(i * 7 + 3);
    timg[0] = 8'd0;
    send_load(1'b0, 1'b0);
    check_store("R5");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule